// File: doc/BRIEF.md
# TDM Serial Audio Transmitter (Slave Timing)

This block shifts parallel audio words out on one serial data line of a time-division-multiplexed link. The link's bit clock and its word-length frame sync come from outside. Both are oversampled by the block's own system clock. The block finds their edges and keeps an internal bit and slot sequencer aligned to them. A single-entry holding register takes each word from a small write port. The word moves into a shift register at the start of the slot that carries it. A control register selects the word length, normal or network operation, the bit clock polarity, the number of slots per frame and the value of two output flag pins.

The bit clock has two edges that matter. On the *capture* edge the frame sync is sampled. On the *launch* edge data and flags change. A new frame is recognised when the sampled frame sync goes from low to high. The first data bit then goes out at the very next launch edge. In network mode a per-slot mask keeps the data line released for the unwanted slots. After the last slot the line stays released until the next frame starts. If an enabled slot begins with no word waiting, the slot sends zeros and raises a sticky underrun flag.

Top module: `tdm_tx`

## Requirements
- R1: After reset, `sdo_oe` is 0, `flags` is 0 and `underrun` is 0.
- R2: The frame sync is sampled only on the capture edge of the bit clock. A low-to-high change seen there starts a frame. The MSB of slot 0 is then driven from the next launch edge for one full bit period. This holds wherever the frame sync rises inside the half period before that capture edge. No bit is ever skipped.
- R3: The word-length field, `wr_data[1:0]` of the control register at address 0, selects 8 bits (code 0), 16 bits (code 1) or 24 bits (codes 2 and 3). Words written to address 2 are right-aligned: only the low word-length bits are sent. They go out MSB first, one bit per launch edge.
- R4: With the network bit `wr_data[2]` clear (normal mode), each frame carries exactly one slot, driven during the whole slot. The slot count field and the slot mask are ignored.
- R5: With the network bit set, each frame carries `wr_data[7:4]` + 1 consecutive slots of one word length each.
- R6: In network mode, slot s is enabled by bit s of the mask register at address 2'd1. When that bit is clear, `sdo_oe` is 0 for the whole slot and no word is taken from the holding register.
- R7: Once the last bit of the last slot has been sent, `sdo_oe` drops at the next launch edge. It stays 0 until the launch edge that starts the next frame.
- R8: `flags` takes the value of control bits `wr_data[9:8]` at the launch edge that starts each slot. In normal mode this is each frame. Writing the control register at other times does not change `flags`, and the pins never change before that launch edge.
- R9: If an enabled slot starts while the holding register is empty, the slot sends all zeros with `sdo_oe` at 1 and `underrun` is set. A write to address 2 clears `underrun`.
- R10: With the polarity bit `wr_data[3]` clear, the launch edge is the bit clock's rising edge and the capture edge is its falling edge. With the bit set, the two are swapped.
- R11: A write to address 2 fills the one-word holding register. The start of an enabled slot takes the word and empties the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 slot mask, 2 data word |
| wr_data | input | 24 | Register write data |
| bclk | input | 1 | External serial bit clock |
| fsync | input | 1 | External word-length frame sync |
| sdo | output | 1 | Serial data; meaningful only while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Drive enable for the serial data pad (0 = high impedance) |
| flags | output | 2 | Output flag pins, updated at slot starts |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The hardest situation to reach is a frame sync edge arriving right next to a bit clock edge. That is where a transmitter could take its first bit as already sent. The bench moves the frame sync rise to each quarter of the launch half period, from the same oversampling clock as the launch edge up to the one just before the capture edge. In every case it checks that the MSB is present for the whole first bit. A second hard case is a control register write inside a slot. The bench rewrites the flag field during every network slot. It then samples the flag pins just before the next launch edge, to show they move only on the launch edge that begins the next slot.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int WORD_W    = 24;
  localparam int MAX_SLOTS = 16;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int FLAG_W    = 2;
  localparam int BIT_W     = $clog2(WORD_W + 1);
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [SLOT_W-1:0] div;
    logic              pol;
    logic              net;
    logic [1:0]        wl;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // number of bits in one slot for a word-length code
  function automatic logic [BIT_W-1:0] wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    return BIT_W'(8);
      2'd1:    return BIT_W'(16);
      default: return BIT_W'(24);
    endcase
  endfunction

  // moves a right-aligned word to the MSB end of the shifter
  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] code);
    case (code)
      2'd0:    return {w[7:0], 16'h0000};
      2'd1:    return {w[15:0], 8'h00};
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/tdm_tx_edge.sv
module tdm_tx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic pol,
  output logic launch_ev,
  output logic capture_ev,
  output logic fs_start
);
  logic bclk_d;
  logic fs_cap;
  logic rise_ev;
  logic fall_ev;

  assign rise_ev    = bclk & ~bclk_d;
  assign fall_ev    = ~bclk & bclk_d;
  assign launch_ev  = pol ? fall_ev : rise_ev;
  assign capture_ev = pol ? rise_ev : fall_ev;
  assign fs_start   = capture_ev & fsync & ~fs_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      fs_cap <= 1'b0;
    end else begin
      bclk_d <= bclk;
      if (capture_ev) fs_cap <= fsync;
    end
  end
endmodule

// File: rtl/tdm_tx_regs.sv
module tdm_tx_regs
  import tdm_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 slot_load,
  output ctrl_t                ctrl,
  output logic [MAX_SLOTS-1:0] slot_mask,
  output logic [WORD_W-1:0]    hold_word,
  output logic                 hold_full,
  output logic                 underrun
);
  logic wr_ctrl, wr_mask, wr_word;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_mask = wr_en && (wr_addr == ADDR_MASK);
  assign wr_word = wr_en && (wr_addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      slot_mask <= '0;
      hold_word <= '0;
      hold_full <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_mask) slot_mask <= wr_data[MAX_SLOTS-1:0];
      if (wr_word) begin
        hold_word <= wr_data;
        hold_full <= 1'b1;
        underrun  <= 1'b0;
      end else begin
        if (slot_load) hold_full <= 1'b0;
        if (slot_load && !hold_full) underrun <= 1'b1;
      end
    end
  end

  // R9
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(slot_load && !hold_full));

  // R11
  hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_full) |-> $past(slot_load));
endmodule

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
  import tdm_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_ev,
  input  logic                 fs_start,
  input  logic [1:0]           wl_code,
  input  logic                 net,
  input  logic [SLOT_W-1:0]    div,
  input  logic [FLAG_W-1:0]    flag_cfg,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  input  logic [WORD_W-1:0]    hold_word,
  input  logic                 hold_full,
  output logic                 slot_load,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic [FLAG_W-1:0]    flags
);
  logic              pend, active;
  logic [SLOT_W-1:0] slot_cnt, last_idx, slot_idx;
  logic [BIT_W-1:0]  bit_cnt, wl_n;
  logic [WORD_W-1:0] shreg, load_word;
  logic last_bit, last_slot, frame_go, next_go, frame_end, slot_go, slot_en;

  always_comb begin
    wl_n      = wl_bits(wl_code);
    last_idx  = net ? div : '0;
    last_bit  = (bit_cnt == wl_n - 1'b1);
    last_slot = (slot_cnt == last_idx);
    frame_go  = launch_ev & pend;
    next_go   = launch_ev & active & ~pend & last_bit & ~last_slot;
    frame_end = launch_ev & active & ~pend & last_bit & last_slot;
    slot_go   = frame_go | next_go;
    slot_idx  = frame_go ? '0 : slot_cnt + 1'b1;
    slot_en   = net ? slot_mask[slot_idx] : 1'b1;
    load_word = hold_full ? align_msb(hold_word, wl_code) : '0;
  end

  assign slot_load = slot_go & slot_en;
  assign sdo       = shreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      active   <= 1'b0;
      slot_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      sdo_oe   <= 1'b0;
      flags    <= '0;
    end else begin
      if (fs_start)       pend <= 1'b1;
      else if (launch_ev) pend <= 1'b0;

      if (slot_go) begin
        active   <= 1'b1;
        slot_cnt <= slot_idx;
        bit_cnt  <= '0;
        sdo_oe   <= slot_en;
        shreg    <= slot_en ? load_word : '0;
        flags    <= flag_cfg;
      end else if (frame_end) begin
        active <= 1'b0;
        sdo_oe <= 1'b0;
      end else if (launch_ev && active) begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= shreg << 1;
      end
    end
  end

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (slot_cnt == '0 && bit_cnt == '0));

  // R8
  flag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags) |-> $past(launch_ev));

  // R6
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_oe) |-> $past(launch_ev));

  // R7
  gap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !sdo_oe);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              bclk,
  input  logic              fsync,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [FLAG_W-1:0] flags,
  output logic              underrun
);
  ctrl_t                ctrl;
  logic [MAX_SLOTS-1:0] slot_mask;
  logic [WORD_W-1:0]    hold_word;
  logic                 hold_full;
  logic                 slot_load;
  logic                 launch_ev, capture_ev, fs_start;

  tdm_tx_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .fsync      (fsync),
    .pol        (ctrl.pol),
    .launch_ev  (launch_ev),
    .capture_ev (capture_ev),
    .fs_start   (fs_start)
  );

  tdm_tx_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .slot_load (slot_load),
    .ctrl      (ctrl),
    .slot_mask (slot_mask),
    .hold_word (hold_word),
    .hold_full (hold_full),
    .underrun  (underrun)
  );

  tdm_tx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_ev (launch_ev),
    .fs_start  (fs_start),
    .wl_code   (ctrl.wl),
    .net       (ctrl.net),
    .div       (ctrl.div),
    .flag_cfg  (ctrl.flags),
    .slot_mask (slot_mask),
    .hold_word (hold_word),
    .hold_full (hold_full),
    .slot_load (slot_load),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .flags     (flags)
  );

  // R10
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_start |-> !launch_ev);
endmodule

// File: tb/tdm_tx_tb.sv
module tdm_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [23:0] wr_data;
  logic        bclk, fsync;
  logic        sdo, sdo_oe, underrun;
  logic [1:0]  flags;

  int checks = 0;
  int errors = 0;
  int frame_no = 0;
  logic launch_lvl = 1'b1;
  logic [1:0] prev_flags = 2'd0;
  logic s_oe, s_sdo, s_ur;
  logic [1:0] s_fa, s_fb;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_tx u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bclk(bclk), .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .flags(flags),
    .underrun(underrun)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s (frame %0d): actual %0h expected %0h", req, what, frame_no, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one bit clock period of 8 system clocks: launch half, then capture half
  task automatic bit_period(input logic fs_v, input int fs_ph, input logic do_wr,
                            input logic [1:0] wa, input logic [23:0] wd);
    @(negedge clk);
    bclk = launch_lvl;
    if (fs_ph == 0) fsync = fs_v;
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      if (fs_ph == i) fsync = fs_v;
      if (i == 2) begin
        s_oe = sdo_oe; s_sdo = sdo; s_fa = flags;
        if (do_wr) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      end
      if (i == 3) wr_en = 1'b0;
    end
    @(negedge clk);
    bclk = ~launch_lvl;
    for (int i = 1; i < 4; i++) @(negedge clk);
    s_fb = flags; s_ur = underrun;
  endtask

  function automatic logic [23:0] wpat(input int f, input int k);
    return 24'h5A3C96 ^ 24'((k + 1) * 24'h1357) ^ 24'(f * 24'h2468A);
  endfunction

  function automatic logic [1:0] fv(input int s);
    return 2'((frame_no + s) & 3);
  endfunction

  task automatic run_frame(input int wl_code, input int nsl, input logic net,
                           input logic [15:0] msk, input int ph, input logic feed,
                           input logic pol_v);
    int wl;
    int div;
    int nper;
    logic en [16];
    logic any_en;
    wl = (wl_code == 0) ? 8 : (wl_code == 1) ? 16 : 24;
    div = net ? nsl - 1 : 3;
    launch_lvl = ~pol_v;
    any_en = 1'b0;
    for (int s = 0; s < 16; s++) begin
      en[s] = (s < nsl) && (net ? msk[s] : (s == 0));
      if (en[s]) any_en = 1'b1;
    end
    wr(2'd0, {14'd0, fv(0), 4'(div), pol_v, net, 2'(wl_code)});
    wr(2'd1, {8'd0, msk});
    if (feed) begin
      for (int s = 0; s < nsl; s++)
        if (en[s]) begin wr(2'd2, wpat(frame_no, s)); break; end
    end
    nper = 2 + nsl * wl;
    for (int p = 0; p < nper; p++) begin
      logic do_w;
      logic [1:0] wa;
      logic [23:0] wd;
      int s, b;
      do_w = 1'b0; wa = 2'd0; wd = 24'd0;
      s = (p >= 1) ? (p - 1) / wl : 0;
      b = (p >= 1) ? (p - 1) % wl : 0;
      if (p >= 1 && p <= nsl * wl) begin
        if (b == 0 && en[s] && feed) begin
          for (int t = s + 1; t < nsl; t++)
            if (en[t]) begin do_w = 1'b1; wa = 2'd2; wd = wpat(frame_no, t); break; end
        end
        if (b == 1 && net && s + 1 < nsl) begin
          do_w = 1'b1; wa = 2'd0;
          wd = {14'd0, fv(s + 1), 4'(div), pol_v, net, 2'(wl_code)};
        end
      end
      bit_period(p < wl, (p == 0) ? ph : 0, do_w, wa, wd);
      if (p == 0) begin
        chk("R7", "idle before frame oe", 32'(s_oe), 32'd0);
        chk("R8", "flags not early before frame", 32'(s_fb), 32'(prev_flags));
      end else if (p <= nsl * wl) begin
        chk(net ? "R6" : "R4", "slot oe", 32'(s_oe), 32'(en[s]));
        if (en[s]) begin
          logic [23:0] w;
          w = feed ? wpat(frame_no, s) : 24'd0;
          chk(feed ? (p == 1 ? "R2" : "R3") : "R9", "data bit", 32'(s_sdo),
              32'((w >> (wl - 1 - b)) & 24'd1));
        end
        if (b == 0) chk("R8", "flags at slot start", 32'(s_fa), 32'(fv(s)));
        if (b == wl - 1) chk("R8", "flags held to slot end", 32'(s_fb), 32'(fv(s)));
        if (b == wl - 1 && s == nsl - 1 && net)
          chk("R5", "oe on last slot bit", 32'(s_oe), 32'(en[s]));
      end else begin
        chk("R7", "gap after last slot oe", 32'(s_oe), 32'd0);
      end
    end
    if (!feed) begin
      chk("R9", "underrun set", 32'(s_ur), 32'(any_en));
      wr(2'd2, 24'h000000);
      chk("R9", "underrun cleared by write", 32'(underrun), 32'd0);
      wr(2'd2, 24'h000000);
    end else begin
      chk("R11", "no underrun when fed", 32'(s_ur), 32'd0);
    end
    prev_flags = fv(nsl - 1);
    frame_no++;
  endtask

  task automatic t_reset;
    chk("R1", "oe after reset", 32'(sdo_oe), 32'd0);
    chk("R1", "flags after reset", 32'(flags), 32'd0);
    chk("R1", "underrun after reset", 32'(underrun), 32'd0);
  endtask

  task automatic t_normal;
    run_frame(0, 1, 1'b0, 16'h0000, 0, 1'b1, 1'b0);   // R4 8-bit, fs with launch
    run_frame(1, 1, 1'b0, 16'h0000, 3, 1'b1, 1'b0);   // R2 fs just before capture
    run_frame(3, 1, 1'b0, 16'h0000, 1, 1'b1, 1'b0);   // R3 code 3 = 24 bits
  endtask

  task automatic t_network;
    run_frame(0, 4, 1'b1, 16'h000F, 2, 1'b1, 1'b0);   // R5 four slots
    run_frame(0, 6, 1'b1, 16'h002D, 1, 1'b1, 1'b0);   // R6 sparse mask
    run_frame(1, 3, 1'b1, 16'h0006, 0, 1'b1, 1'b0);   // R6 slot 0 off
  endtask

  task automatic t_underrun;
    run_frame(0, 2, 1'b1, 16'h0003, 2, 1'b0, 1'b0);   // R9 empty holding register
    // the underrun task ends with a full holding register; drain it with a fed frame
    run_frame(0, 1, 1'b0, 16'h0000, 0, 1'b1, 1'b0);
  endtask

  task automatic t_polarity;
    run_frame(0, 1, 1'b0, 16'h0000, 3, 1'b1, 1'b1);   // R10 swapped edges
    run_frame(0, 3, 1'b1, 16'h0005, 1, 1'b1, 1'b1);   // R10 network, swapped
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0;
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 24'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_network();
    t_underrun();
    t_polarity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule